// File: doc/BRIEF.md
# Identification Checksum Validator

This block checks the integrity of a 256-byte identification space as it streams past. The space holds two protected ranges that do not overlap. Each range is followed by one stored checksum byte. The block takes one byte per transfer, tagged with its offset. For each range it keeps a running sum of the bytes, truncated to 8 bits. When the range's stored checksum byte arrives, the block compares the running sum with that byte and latches a pass/fail verdict for the range.

A controller that reads the identification space starts a pass by pulsing `start_i`. It then streams the bytes in ascending offset order through a valid/ready interface. The block never applies back-pressure while a pass is in progress. `in_ready_o` is low only during reset and in the cycle that `start_i` is high. A beat that is offered in either of those cycles is not taken, and the sender must hold it and offer it again. The block gives a separate verdict for each range, a one-cycle done strobe when the extended checksum byte has been consumed, and an overall valid flag. A sticky error flag reports any beat whose offset breaks the ascending order.

Top module: `idsum_checker`

## Requirements
- R1: A beat transfers when `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high whenever the block is out of reset and `start_i` is low, and low otherwise.
- R2: The base verdict compares the low 8 bits of the sum of the bytes at offsets 0 through 62 with the byte at offset 63. In the cycle after the offset-63 beat, `base_valid_o` is 1 and `base_ok_o` is 1 on a match or 0 on a mismatch.
- R3: The extended verdict compares the low 8 bits of the sum of the bytes at offsets 64 through 94 with the byte at offset 95. In the cycle after the offset-95 beat, `ext_valid_o` is 1 and `ext_ok_o` shows the result.
- R4: Bytes at offsets 96 through 255 change neither verdict, neither valid flag and the overall flag, and they raise no done strobe.
- R5: `id_valid_o` is 1 exactly when both verdicts are valid, both are passing, and no order error is pending.
- R6: `done_o` is high for exactly one cycle, the cycle after the offset-95 beat is accepted.
- R7: A cycle with `start_i` high clears both sums, both verdicts, both valid flags and the order error. It also resets the expected offset to 0. A beat offered in that cycle is not accepted.
- R8: Each accepted beat must carry the offset one above the previous accepted beat, or 0 for the first beat after reset or start. A beat that breaks this rule sets `order_err_o` in the next cycle. The flag stays set until the next start or reset, and the expected offset resynchronizes to the offending offset plus one.
- R9: After reset all outputs are 0 except `in_ready_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new pass and clear all state |
| in_valid_i | input | 1 | A beat is offered |
| in_ready_o | output | 1 | The block accepts the offered beat |
| in_offset_i | input | 8 | Offset of the offered byte |
| in_data_i | input | 8 | Value of the offered byte |
| base_ok_o | output | 1 | Base range checksum matched |
| base_valid_o | output | 1 | Base verdict is available |
| ext_ok_o | output | 1 | Extended range checksum matched |
| ext_valid_o | output | 1 | Extended verdict is available |
| done_o | output | 1 | One-cycle strobe after the offset-95 beat |
| id_valid_o | output | 1 | Both ranges pass and the order was kept |
| order_err_o | output | 1 | Sticky out-of-order offset error |

## Verification
A running sum that picks up a wrong byte does not show at the ports until its checksum offset arrives. It then appears one cycle later as a flipped verdict on `base_ok_o` or `ext_ok_o`, and therefore on `id_valid_o`. A wrong expected-offset counter shows in the cycle after the next beat as a spurious or missing `order_err_o`. A range decoder with a wrong boundary shows only through the verdict of the range it belongs to. For that reason the tests corrupt each stored checksum separately, use data whose sums wrap past 255, and stream the offsets past 95 to confirm the latched state holds.

// File: rtl/idsum_pkg.sv
package idsum_pkg;
  localparam int ID_OFF_W  = 8;
  localparam int ID_DATA_W = 8;
  localparam int ID_NUM_RNG = 2;
  // Range 0 is the base range; the last range drives the done strobe.
  localparam int unsigned ID_RNG_LO [ID_NUM_RNG] = '{0, 64};
  localparam int unsigned ID_RNG_HI [ID_NUM_RNG] = '{62, 94};
  localparam int unsigned ID_RNG_CK [ID_NUM_RNG] = '{63, 95};
endpackage

// File: rtl/idsum_range_acc.sv
module idsum_range_acc #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter int unsigned LO = 0,
  parameter int unsigned HI = 62,
  parameter int unsigned CK = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              beat_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ok_o,
  output logic              vld_o,
  output logic              fin_o
);
  localparam logic [OFF_W-1:0] LO_V   = OFF_W'(LO);
  localparam logic [OFF_W-1:0] SPAN_V = OFF_W'(HI - LO);
  localparam logic [OFF_W-1:0] CK_V   = OFF_W'(CK);

  logic [DATA_W-1:0] sum_q;
  logic [OFF_W-1:0]  rel;
  logic              in_rng, at_ck;

  // Wrapping subtraction folds the two range bounds into one compare.
  assign rel    = off_i - LO_V;
  assign in_rng = (rel <= SPAN_V);
  assign at_ck  = (off_i == CK_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      ok_o  <= 1'b0;
      vld_o <= 1'b0;
      fin_o <= 1'b0;
    end else if (clr_i) begin
      sum_q <= '0;
      ok_o  <= 1'b0;
      vld_o <= 1'b0;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (beat_i) begin
        if (in_rng) sum_q <= sum_q + data_i;
        if (at_ck) begin
          ok_o  <= (sum_q == data_i);
          vld_o <= 1'b1;
          fin_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/idsum_order_mon.sv
module idsum_order_mon #(
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             beat_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             err_o
);
  logic [OFF_W-1:0] exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      err_o <= 1'b0;
    end else if (clr_i) begin
      exp_q <= '0;
      err_o <= 1'b0;
    end else if (beat_i) begin
      if (off_i != exp_q) err_o <= 1'b1;
      exp_q <= off_i + OFF_W'(1);
    end
  end
endmodule

// File: rtl/idsum_checker.sv
module idsum_checker
  import idsum_pkg::*;
#(
  parameter int OFF_W  = ID_OFF_W,
  parameter int DATA_W = ID_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OFF_W-1:0]  in_offset_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              base_ok_o,
  output logic              base_valid_o,
  output logic              ext_ok_o,
  output logic              ext_valid_o,
  output logic              done_o,
  output logic              id_valid_o,
  output logic              order_err_o
);
  localparam int LAST = ID_NUM_RNG - 1;

  logic                  beat;
  logic [ID_NUM_RNG-1:0] rng_ok, rng_vld, rng_fin;

  assign in_ready_o = rst_n & ~start_i;
  assign beat       = in_valid_i & in_ready_o;

  for (genvar g = 0; g < ID_NUM_RNG; g++) begin : g_rng
    idsum_range_acc #(
      .OFF_W (OFF_W),
      .DATA_W(DATA_W),
      .LO    (ID_RNG_LO[g]),
      .HI    (ID_RNG_HI[g]),
      .CK    (ID_RNG_CK[g])
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_i),
      .beat_i(beat),
      .off_i (in_offset_i),
      .data_i(in_data_i),
      .ok_o  (rng_ok[g]),
      .vld_o (rng_vld[g]),
      .fin_o (rng_fin[g])
    );
  end

  idsum_order_mon #(.OFF_W(OFF_W)) u_ord (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_i),
    .beat_i(beat),
    .off_i (in_offset_i),
    .err_o (order_err_o)
  );

  assign base_ok_o    = rng_ok[0];
  assign base_valid_o = rng_vld[0];
  assign ext_ok_o     = rng_ok[LAST];
  assign ext_valid_o  = rng_vld[LAST];
  assign done_o       = rng_fin[LAST];
  assign id_valid_o   = (&rng_vld) & (&rng_ok) & ~order_err_o;
endmodule

// File: rtl/idsum_checker_sva.sv
module idsum_checker_sva #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [OFF_W-1:0]  in_offset_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              base_ok_o,
  input logic              base_valid_o,
  input logic              ext_ok_o,
  input logic              ext_valid_o,
  input logic              done_o,
  input logic              id_valid_o,
  input logic              order_err_o
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !in_ready_o);

  assert_base_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_offset_i == OFF_W'(63)) |=> base_valid_o);

  assert_ext_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_offset_i == OFF_W'(95)) |=> (ext_valid_o && done_o));

  assert_overall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_o |-> (base_ok_o && ext_ok_o && base_valid_o && !order_err_o));

  assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ext_valid_o);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!base_valid_o && !ext_valid_o && !done_o && !order_err_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (order_err_o && !start_i) |=> order_err_o);
endmodule

bind idsum_checker idsum_checker_sva #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .in_offset_i(in_offset_i), .in_data_i(in_data_i),
  .base_ok_o(base_ok_o), .base_valid_o(base_valid_o), .ext_ok_o(ext_ok_o),
  .ext_valid_o(ext_valid_o), .done_o(done_o), .id_valid_o(id_valid_o),
  .order_err_o(order_err_o)
);

// File: tb/idsum_checker_tb.sv
`timescale 1ns/1ps
module idsum_checker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_offset_i = '0;
  logic [7:0] in_data_i = '0;
  logic in_ready_o, base_ok_o, base_valid_o, ext_ok_o, ext_valid_o;
  logic done_o, id_valid_o, order_err_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [256];

  always #2 clk = ~clk;

  idsum_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_offset_i(in_offset_i), .in_data_i(in_data_i),
    .base_ok_o(base_ok_o), .base_valid_o(base_valid_o), .ext_ok_o(ext_ok_o),
    .ext_valid_o(ext_valid_o), .done_o(done_o), .id_valid_o(id_valid_o),
    .order_err_o(order_err_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  // Fill an image and store correct checksums at 63 and 95.
  task automatic build(input int seed);
    logic [7:0] s;
    for (int i = 0; i < 256; i++) img[i] = 8'((i * seed + seed * 7 + 200) & 255);
    s = '0;
    for (int i = 0; i <= 62; i++) s = s + img[i];
    img[63] = s;
    s = '0;
    for (int i = 64; i <= 94; i++) s = s + img[i];
    img[95] = s;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid_i = 1'b0;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Presents one beat; returns at the negedge after the accepting edge.
  task automatic send(input int off, input logic [7:0] d);
    in_valid_i  = 1'b1;
    in_offset_i = 8'(off);
    in_data_i   = d;
    @(posedge clk);
    @(negedge clk);
    in_valid_i  = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready_o, 1'b1, "R9/R1 ready after reset");
    chk(base_valid_o | ext_valid_o | base_ok_o | ext_ok_o, 1'b0, "R9 flags after reset");
    chk(done_o | id_valid_o | order_err_o, 1'b0, "R9 done/id/err after reset");
  endtask

  // Full pass; expected verdicts come from whether img checksums were corrupted.
  task automatic t_stream(input logic exp_b, input logic exp_e, input string tag);
    pulse_start();
    for (int i = 0; i <= 95; i++) begin
      send(i, img[i]);
      if (i == 62) chk(base_valid_o, 1'b0, {"R2 base not valid before 63 ", tag});
      if (i == 63) begin
        chk(base_valid_o, 1'b1, {"R2 base valid ", tag});
        chk(base_ok_o, exp_b, {"R2 base verdict ", tag});
        chk(ext_valid_o, 1'b0, {"R3 ext not yet valid ", tag});
      end
      if (i == 94) chk(done_o, 1'b0, {"R6 no early done ", tag});
    end
    chk(ext_valid_o, 1'b1, {"R3 ext valid ", tag});
    chk(ext_ok_o, exp_e, {"R3 ext verdict ", tag});
    chk(done_o, 1'b1, {"R6 done pulse ", tag});
    chk(id_valid_o, exp_b & exp_e, {"R5 overall ", tag});
    chk(order_err_o, 1'b0, {"R8 no order error ", tag});
    @(posedge clk);
    @(negedge clk);
    chk(done_o, 1'b0, {"R6 done one cycle ", tag});
  endtask

  task automatic t_tail();
    logic saw_done;
    saw_done = 1'b0;
    for (int i = 96; i < 256; i++) begin
      send(i, 8'(i ^ 8'h3C));
      saw_done |= done_o;
    end
    chk(saw_done, 1'b0, "R4 no done from tail bytes");
    chk(base_ok_o & ext_ok_o & base_valid_o & ext_valid_o, 1'b1, "R4 verdicts stable");
    chk(id_valid_o, 1'b1, "R4 overall stable");
  endtask

  task automatic t_order();
    pulse_start();
    for (int i = 0; i < 10; i++) send(i, img[i]);
    chk(order_err_o, 1'b0, "R8 in-order prefix");
    send(11, img[11]);
    chk(order_err_o, 1'b1, "R8 skip detected");
    for (int i = 12; i <= 95; i++) send(i, img[i]);
    chk(order_err_o, 1'b1, "R8 error sticky");
    chk(id_valid_o, 1'b0, "R5 overall low on order error");
  endtask

  task automatic t_start_clear();
    // Start together with an offered beat: beat refused, state cleared.
    @(negedge clk);
    start_i = 1'b1;
    in_valid_i = 1'b1;
    in_offset_i = 8'd0;
    in_data_i = img[0];
    #0.5;
    chk(in_ready_o, 1'b0, "R1 ready low during start");
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    in_valid_i = 1'b0;
    chk(order_err_o | base_valid_o | ext_valid_o | id_valid_o, 1'b0, "R7 state cleared");
    // Had the offset-0 beat been accepted, offset 0 again would be out of order.
    send(0, img[0]);
    chk(order_err_o, 1'b0, "R7 beat with start not accepted");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    build(37);
    t_stream(1'b1, 1'b1, "good");
    t_tail();
    build(251);
    t_stream(1'b1, 1'b1, "wrapping sums");
    img[63] = img[63] ^ 8'h5A;
    t_stream(1'b0, 1'b1, "bad base");
    build(251);
    img[95] = img[95] + 8'd1;
    t_stream(1'b1, 1'b0, "bad ext");
    build(13);
    t_order();
    t_start_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule